// File: doc/BRIEF.md
# Single-Channel DMA Bus Handshake Sequencer

This block moves a run of bytes between one I/O port and consecutive memory locations while it holds the system buses on loan from a host processor. A peripheral raises its request line. The sequencer then asks the host for the buses and waits for the grant. Once granted, it takes the address bus, latches the upper address, acknowledges the peripheral and strobes one byte. It repeats this for each remaining byte. A peripheral-to-memory transfer pairs I/O read with memory write. A memory-to-peripheral transfer pairs memory read with I/O write.

The channel is set up through a one-cycle load pulse that carries a start address, the byte count minus one, the direction and an auto-reload flag. When the last byte is done, or when an external terminate input ends the run early, the sequencer signals end of process and hands the buses back. If auto-reload is set, it also restores the start address and count. If the peripheral withdraws its request between bytes, the buses go back to the host and the transfer resumes later from where it stopped.

Top module: `dma_xfer_seq`

## Requirements
- R1: After a load, a high `dev_req` raises `hold_req` on the following cycle. `addr_en`, `addr_stb`, `dev_ack` and all four strobes stay low until `hold_ack` has been sampled high.
- R2: The cycle after `hold_ack` is sampled high, `addr_en`, `addr_stb` and `dev_ack` are all high, and `addr_out` shows the current address. `addr_stb` lasts one cycle per byte, and the strobe cycle for that byte follows it directly.
- R3: `dev_ack` is high only while `addr_en` is high.
- R4: Each byte takes exactly one strobe cycle. With `cfg_dir`=0, `io_rd` and `mem_wr` are high together. With `cfg_dir`=1, `mem_rd` and `io_wr` are high together. The other two strobes stay low.
- R5: The address rises by one for each byte moved and wraps from 16'hFFFF to 16'h0000.
- R6: A loaded count c moves c+1 bytes. `eop_out` is high for one cycle, right after the last strobe cycle. On the cycle after that, `hold_req` and `addr_en` are both low.
- R7: With `cfg_auto`=1, a completed transfer restores the loaded address and count, and the next request repeats the same transfer. With `cfg_auto`=0, the channel disarms: a high `dev_req` then leaves `hold_req` low until the next load.
- R8: If `dev_req` is low at the end of a strobe cycle and bytes remain, the buses are released (`hold_req` low) and `eop_out` is not asserted. A later request resumes at the next address with the remaining count.
- R9: If `eop_in` is high during a strobe cycle, that byte completes and the transfer then ends as in R6, including the reload or disarm of R7.
- R10: During and after reset, every output is low and the channel is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle pulse that loads the channel settings and arms the channel |
| cfg_base_addr | input | 16 | Start memory address |
| cfg_last_cnt | input | 16 | Number of bytes minus one |
| cfg_dir | input | 1 | 0: port to memory, 1: memory to port |
| cfg_auto | input | 1 | Restore address and count when a transfer completes |
| dev_req | input | 1 | Peripheral request |
| hold_ack | input | 1 | Host grant: the host's buses are released |
| eop_in | input | 1 | External early-terminate input |
| hold_req | output | 1 | Bus request to the host |
| addr_en | output | 1 | Sequencer drives the address bus |
| addr_stb | output | 1 | Upper-address latch strobe |
| dev_ack | output | 1 | Peripheral acknowledge |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| eop_out | output | 1 | End-of-process indication |
| addr_out | output | 16 | Memory address |

## Verification
The properties assume three things about the environment:
- the host keeps `hold_ack` high for as long as `hold_req` is high, and drops it only after `hold_req` has fallen;
- `cfg_load` arrives only while the channel is idle;
- `eop_in` matters only during a strobe cycle.

The bench host model grants after a programmable delay and withdraws only once the request has fallen. Loads are issued only between transfers. The early terminate and the request drop are timed against observed strobe cycles, so every stimulus stays inside these assumptions.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_ADDR = 3'd2,
    ST_XFER = 3'd3,
    ST_DONE = 3'd4
  } dma_state_e;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          ld_dir,
  input  logic          ld_auto,
  input  logic          step,
  input  logic          finish,
  output logic [AW-1:0] cur_addr,
  output logic          last,
  output logic          armed,
  output logic          dir
);
  logic [AW-1:0] base_addr_q, base_addr_d, cur_addr_q, cur_addr_d;
  logic [CW-1:0] base_cnt_q, base_cnt_d, cur_cnt_q, cur_cnt_d;
  logic          armed_d, dir_d, auto_q, auto_d;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    cur_addr_d  = cur_addr_q;
    cur_cnt_d   = cur_cnt_q;
    armed_d     = armed;
    dir_d       = dir;
    auto_d      = auto_q;
    if (load) begin
      base_addr_d = ld_addr;
      base_cnt_d  = ld_cnt;
      cur_addr_d  = ld_addr;
      cur_cnt_d   = ld_cnt;
      dir_d       = ld_dir;
      auto_d      = ld_auto;
      armed_d     = 1'b1;
    end else if (finish) begin
      if (auto_q) begin
        cur_addr_d = base_addr_q;
        cur_cnt_d  = base_cnt_q;
      end else begin
        armed_d    = 1'b0;
      end
    end else if (step) begin
      cur_addr_d = cur_addr_q + AW'(1);
      cur_cnt_d  = cur_cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      armed       <= 1'b0;
      dir         <= 1'b0;
      auto_q      <= 1'b0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_addr_q  <= cur_addr_d;
      cur_cnt_q   <= cur_cnt_d;
      armed       <= armed_d;
      dir         <= dir_d;
      auto_q      <= auto_d;
    end
  end

  assign cur_addr = cur_addr_q;
  assign last     = (cur_cnt_q == '0);
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       dev_req,
  input  logic       hold_ack,
  input  logic       last,
  input  logic       eop_in,
  output dma_state_e state,
  output logic       step,
  output logic       finish
);
  dma_state_e state_d;

  always_comb begin
    state_d = state;
    step    = 1'b0;
    finish  = 1'b0;
    unique case (state)
      ST_IDLE: if (armed && dev_req) state_d = ST_HOLD;
      ST_HOLD: if (hold_ack) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_XFER;
      ST_XFER: begin
        step = 1'b1;
        if (last || eop_in) begin
          finish  = 1'b1;
          state_d = ST_DONE;
        end else if (dev_req) begin
          state_d = ST_ADDR;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
  import dma_seq_pkg::*;
(
  input  dma_state_e state,
  input  logic       dir,
  output logic       hold_req,
  output logic       addr_en,
  output logic       addr_stb,
  output logic       dev_ack,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       io_rd,
  output logic       io_wr,
  output logic       eop_out
);
  logic xfer;

  always_comb begin
    xfer     = (state == ST_XFER);
    hold_req = (state != ST_IDLE);
    addr_en  = (state == ST_ADDR) || xfer || (state == ST_DONE);
    addr_stb = (state == ST_ADDR);
    dev_ack  = (state == ST_ADDR) || xfer;
    mem_rd   = xfer &&  dir;
    io_wr    = xfer &&  dir;
    mem_wr   = xfer && !dir;
    io_rd    = xfer && !dir;
    eop_out  = (state == ST_DONE);
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base_addr,
  input  logic [CNT_W-1:0]  cfg_last_cnt,
  input  logic              cfg_dir,
  input  logic              cfg_auto,
  input  logic              dev_req,
  input  logic              hold_ack,
  input  logic              eop_in,
  output logic              hold_req,
  output logic              addr_en,
  output logic              addr_stb,
  output logic              dev_ack,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              eop_out,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_q;
  logic                   armed, last, dir, step, finish;
  dma_state_e             state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_sync[SYNC_STAGES-1];

  dma_seq_regs #(.AW(ADDR_W), .CW(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_q), .load(cfg_load), .ld_addr(cfg_base_addr),
    .ld_cnt(cfg_last_cnt), .ld_dir(cfg_dir), .ld_auto(cfg_auto),
    .step(step), .finish(finish), .cur_addr(addr_out), .last(last),
    .armed(armed), .dir(dir)
  );

  dma_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_q), .armed(armed), .dev_req(dev_req),
    .hold_ack(hold_ack), .last(last), .eop_in(eop_in), .state(state),
    .step(step), .finish(finish)
  );

  dma_seq_decode dec_i (
    .state(state), .dir(dir), .hold_req(hold_req), .addr_en(addr_en),
    .addr_stb(addr_stb), .dev_ack(dev_ack), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .eop_out(eop_out)
  );
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          addr_en,
  input logic          addr_stb,
  input logic          dev_ack,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          eop_out,
  input logic [AW-1:0] addr_out
);
  p_grant_before_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_en) |-> ($past(hold_req) && $past(hold_ack)));

  p_bus_needs_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> hold_req);

  p_stb_then_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> (mem_rd || mem_wr));

  p_ack_on_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> addr_en);

  p_strobe_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == io_wr) && (mem_wr == io_rd) && !(mem_rd && mem_wr));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) ##1 addr_stb) |-> (addr_out == $past(addr_out) + AW'(1)));

  p_eop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |=> (!hold_req && !addr_en && !eop_out));

  p_eop_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eop_out) |-> $past(mem_rd || mem_wr));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .addr_en(addr_en), .addr_stb(addr_stb), .dev_ack(dev_ack), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .eop_out(eop_out),
  .addr_out(addr_out)
);

// File: tb/dma_xfer_seq_tb_top.sv
module dma_xfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_dir = 1'b0, cfg_auto = 1'b0;
  logic [15:0] cfg_base_addr = '0, cfg_last_cnt = '0;
  logic        dev_req = 1'b0, hold_ack = 1'b0, eop_in = 1'b0;
  logic        hold_req, addr_en, addr_stb, dev_ack, mem_rd, mem_wr, io_rd, io_wr, eop_out;
  logic [15:0] addr_out;

  int vectors = 0;
  int fails   = 0;
  int ack_dly = 1;
  int hold_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base_addr(cfg_base_addr),
    .cfg_last_cnt(cfg_last_cnt), .cfg_dir(cfg_dir), .cfg_auto(cfg_auto),
    .dev_req(dev_req), .hold_ack(hold_ack), .eop_in(eop_in), .hold_req(hold_req),
    .addr_en(addr_en), .addr_stb(addr_stb), .dev_ack(dev_ack), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .eop_out(eop_out),
    .addr_out(addr_out)
  );

  // host model: grants ack_dly negedges after the request is seen
  always @(negedge clk) begin
    #1;
    if (hold_req) begin
      hold_cnt = hold_cnt + 1;
      hold_ack = (hold_cnt >= ack_dly);
    end else begin
      hold_cnt = 0;
      hold_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] a, input logic [15:0] c, input bit d, input bit au);
    @(negedge clk);
    cfg_load = 1'b1; cfg_base_addr = a; cfg_last_cnt = c; cfg_dir = d; cfg_auto = au;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic run(input logic [15:0] start, input int cnt, input bit d, input int dly,
                     input int drop_k, input int eop_k);
    int  bytes = 0;
    int  exp_bytes = (eop_k >= 0) ? eop_k + 1 : cnt + 1;
    int  drop_wait = 0;
    bit  fin = 1'b0;
    logic [3:0] stb, exp_stb;
    exp_stb = d ? 4'b1001 : 4'b0110;
    ack_dly = dly;
    dev_req = 1'b1;
    for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
      @(negedge clk);
      eop_in = 1'b0;
      stb = {mem_rd, mem_wr, io_rd, io_wr};
      if (addr_en && !hold_ack) chk(1'b0, "R1 bus taken before grant", 32'(addr_en), 0);
      if (stb != 0 && !hold_ack) chk(1'b0, "R1 strobe before grant", 32'(stb), 0);
      if (addr_stb) begin
        chk(addr_en && dev_ack, "R2 addr_en/dev_ack with addr_stb", {30'd0, addr_en, dev_ack}, 3);
        chk(addr_out == 16'(start + bytes), "R5 address at addr_stb", 32'(addr_out), 32'(16'(start + bytes)));
      end
      if (dev_ack && !addr_en) chk(1'b0, "R3 dev_ack without addr_en", 1, 0);
      if (stb != 0) begin
        chk(stb == exp_stb, "R4 strobe pairing", 32'(stb), 32'(exp_stb));
        chk(addr_out == 16'(start + bytes), "R5 address at strobe", 32'(addr_out), 32'(16'(start + bytes)));
        if (bytes == drop_k) begin dev_req = 1'b0; drop_wait = 1; end
        if (bytes == eop_k) eop_in = 1'b1;
        bytes++;
      end else if (drop_wait > 0) begin
        drop_wait++;
        if (drop_wait == 4) begin
          chk(!hold_req && !eop_out, "R8 bus released on request drop", {30'd0, hold_req, eop_out}, 0);
          dev_req = 1'b1;
          drop_wait = 0;
        end
      end
      if (eop_out) begin
        chk(bytes == exp_bytes, (eop_k >= 0) ? "R9 byte count at early end" : "R6 byte count at end",
            32'(bytes), 32'(exp_bytes));
        @(negedge clk);
        dev_req = 1'b0;
        chk(!hold_req && !addr_en && !eop_out, "R6 release after eop",
            {29'd0, hold_req, addr_en, eop_out}, 0);
        fin = 1'b1;
      end
    end
    if (!fin) chk(1'b0, "R6 eop never seen", 0, 1);
    dev_req = 1'b0;
    eop_in  = 1'b0;
  endtask

  task automatic post_check(input logic [15:0] start, input int cnt, input bit d, input bit au);
    if (au) begin
      run(start, cnt, d, 2, -1, -1); // R7 repeat from restored base
    end else begin
      dev_req = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(!hold_req, "R7 disarmed channel ignores dev_req", 32'(hold_req), 0);
      end
      dev_req = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [15:0] starts [3];
    starts[0] = 16'h0000; starts[1] = 16'hFFFD; starts[2] = 16'h1234;
    dev_req = 1'b1; // R10: request while in reset and disarmed
    repeat (3) @(negedge clk);
    chk({hold_req, addr_en, addr_stb, dev_ack, mem_rd, mem_wr, io_rd, io_wr, eop_out} == 0,
        "R10 outputs in reset", 0, 0);
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk({hold_req, addr_en, addr_stb, dev_ack, mem_rd, mem_wr, io_rd, io_wr, eop_out} == 0,
          "R10 disarmed after reset", {23'd0, hold_req, addr_en, addr_stb, dev_ack, mem_rd, mem_wr, io_rd, io_wr, eop_out}, 0);
    end
    dev_req = 1'b0;

    for (int d = 0; d < 2; d++)
      for (int au = 0; au < 2; au++)
        for (int c = 0; c < 5; c++)
          for (int s = 0; s < 3; s++)
            for (int dl = 1; dl <= 3; dl += 2) begin
              do_load(starts[s], 16'(c), d[0], au[0]);
              run(starts[s], c, d[0], dl, -1, -1);
              post_check(starts[s], c, d[0], au[0]);
            end

    // R8: demand drops part way, with wrap
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 3; k++) begin
        do_load(16'hFFFE, 16'd4, d[0], 1'b0);
        run(16'hFFFE, 4, d[0], 2, k, -1);
        post_check(16'hFFFE, 4, d[0], 1'b0);
      end

    // R9: external terminate, with and without reload
    for (int au = 0; au < 2; au++)
      for (int k = 0; k < 6; k++) begin
        do_load(16'h8000, 16'd5, au[0], au[0]);
        run(16'h8000, 5, au[0], 1, -1, k);
        post_check(16'h8000, 5, au[0], au[0]);
      end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule